// File: doc/BRIEF.md
# Trigger Input Conditioning and Delay

This block takes a bank of asynchronous trigger pins (seven by default), brings each one into the clock domain through a chain of synchronising flops, and then conditions it under control of a small register bank. Each input can be enabled or masked. Its synchronised level can be read back at any time. A sticky flag records that it was seen high, and software clears that flag by writing zero to it.

Every input drives one trigger output. An output either follows the enabled input level directly, or takes the delayed path. On the delayed path a rising edge starts a down-counter loaded with a programmable number of clock ticks (10 ns each at 100 MHz). When the count ends, a single-cycle pulse goes out. A per-output enable gates the final lines. Software reaches the bank through a plain 32-bit write/read port with byte offsets.

Top module: `trig_cond`

## Requirements
- R1: After reset every register reads zero, all catch flags are clear, no delay is counting and every trigger output is low.
- R2: Offset 0x08 returns in bit i the level of input i after the two-flop synchroniser, whatever the input enable. Bits above the input count read zero, and writes to this offset change nothing.
- R3: Offset 0x04 holds the input enable, bit i for input i. A masked input never drives its output, never sets its catch flag and never starts a delay.
- R4: Offset 0x0C holds the catch flags. Bit i becomes 1 on the clock after enabled input i is seen high. A write clears each bit whose data bit is 0 and leaves bits written 1 unchanged. An input still high in the clearing cycle keeps its flag set.
- R5: Offset 0x10 holds the output enables, bit i for output i. A cleared bit holds that output low on both paths and does not affect the catch flag.
- R6: With delay selection bit i clear, output i equals enabled input i's synchronised level, two clocks after the pin changes.
- R7: Offset 0x14 bits 15:0 give the delay D in clock ticks, and bit 16+i selects the delayed path for input i. A rising edge of enabled input i, seen on the clock after synchronisation, yields exactly one one-clock pulse D+1 clocks later, that is D+3 clocks after the pin rises.
- R8: A delay of zero emits the pulse on the clock after the edge is seen (three clocks after the pin rises).
- R9: A rising edge that arrives while that input's delay is still counting is ignored and does not restart or extend the count.
- R10: Writable fields read back as written with unused bits zero (0x04, 0x0C and 0x10 keep the low seven bits, and 0x14 keeps bits 22:0). Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (one delay tick per cycle) |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| trig_pin | input | 7 | Asynchronous trigger inputs |
| trig_out | output | 7 | Conditioned trigger outputs |

## Verification
The embedded properties assume each pin holds steady for at least two clocks, so that the synchroniser never merges a high and a low into one sample. They also assume the delay value stays constant while a lane is counting. The bench changes pins only on falling clock edges, keeps every high and low phase several cycles long, and rewrites the delay register only after every lane has returned to idle. Register writes last exactly one cycle and reads are sampled mid-cycle, so the catch-clear rule and the set-over-clear rule are tested on known cycles.

// File: rtl/trig_cond_pkg.sv
package trig_cond_pkg;
   localparam int REG_AW   = 8;
   localparam int REG_DW   = 32;
   localparam int SEL_LSB  = 16;
   localparam logic [REG_AW-1:0] OFF_IN_EN  = 8'h04;
   localparam logic [REG_AW-1:0] OFF_LEVEL  = 8'h08;
   localparam logic [REG_AW-1:0] OFF_CATCH  = 8'h0C;
   localparam logic [REG_AW-1:0] OFF_OUT_EN = 8'h10;
   localparam logic [REG_AW-1:0] OFF_DLY    = 8'h14;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
   parameter int WIDTH  = 7,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= din;
   end

   for (genvar st = 1; st < STAGES; st++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[st] <= '0;
         else        chain[st] <= chain[st-1];
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/trig_regs.sv
module trig_regs
   import trig_cond_pkg::*;
#(
   parameter int N_TRIG = 7,
   parameter int DLY_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [REG_DW-1:0] reg_wdata,
   output logic [REG_DW-1:0] reg_rdata,
   input  logic [N_TRIG-1:0] lvl_sync,
   output logic [N_TRIG-1:0] in_en,
   output logic [N_TRIG-1:0] out_en,
   output logic [DLY_W-1:0]  dly_val,
   output logic [N_TRIG-1:0] dly_sel
);
   logic [N_TRIG-1:0] catch_q;
   logic [N_TRIG-1:0] lvl_gated;
   logic              wr_catch;
   logic              unused_wdata;

   assign lvl_gated    = lvl_sync & in_en;
   assign wr_catch     = reg_wr && (reg_addr == OFF_CATCH);
   assign unused_wdata = ^reg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_en   <= '0;
         out_en  <= '0;
         dly_val <= '0;
         dly_sel <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            OFF_IN_EN:  in_en  <= reg_wdata[N_TRIG-1:0];
            OFF_OUT_EN: out_en <= reg_wdata[N_TRIG-1:0];
            OFF_DLY: begin
               dly_val <= reg_wdata[DLY_W-1:0];
               dly_sel <= reg_wdata[SEL_LSB +: N_TRIG];
            end
            default: ;
         endcase
      end
   end

   // set has priority over a clearing write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        catch_q <= '0;
      else if (wr_catch) catch_q <= (catch_q & reg_wdata[N_TRIG-1:0]) | lvl_gated;
      else               catch_q <= catch_q | lvl_gated;
   end

   always_comb begin
      case (reg_addr)
         OFF_IN_EN:  reg_rdata = REG_DW'(in_en);
         OFF_LEVEL:  reg_rdata = REG_DW'(lvl_sync);
         OFF_CATCH:  reg_rdata = REG_DW'(catch_q);
         OFF_OUT_EN: reg_rdata = REG_DW'(out_en);
         OFF_DLY:    reg_rdata = REG_DW'(dly_val) | (REG_DW'(dly_sel) << SEL_LSB);
         default:    reg_rdata = '0;
      endcase
   end

   // R4: a flag only falls through a write to the catch offset
   a_r4_catch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_catch |=> (($past(catch_q) & ~catch_q) == '0));

   // R4: an enabled high input sets its flag on the next clock
   a_r4_catch_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_gated != '0) |=> (($past(lvl_gated) & ~catch_q) == '0));
endmodule

// File: rtl/trig_delay_lane.sv
module trig_delay_lane #(
   parameter int DLY_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl,
   input  logic [DLY_W-1:0] dly,
   output logic             pulse
);
   logic             lvl_q;
   logic             busy;
   logic [DLY_W-1:0] cnt;
   logic             rise;

   assign rise = lvl & ~lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
         busy  <= 1'b0;
         cnt   <= '0;
         pulse <= 1'b0;
      end else begin
         lvl_q <= lvl;
         pulse <= 1'b0;
         if (busy) begin
            if (cnt == '0) begin
               pulse <= 1'b1;
               busy  <= 1'b0;
            end else begin
               cnt <= cnt - DLY_W'(1);
            end
         end else if (rise) begin
            if (dly == '0) pulse <= 1'b1;
            else begin
               busy <= 1'b1;
               cnt  <= dly - DLY_W'(1);
            end
         end
      end
   end

   // R7: each pulse lasts exactly one clock
   a_r7_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);

   // R8: zero delay answers an idle edge on the next clock
   a_r8_zero_next: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && rise && dly == '0) |=> pulse);

   // R9: a count in progress continues whatever the input does
   a_r9_keep_count: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt != '0) |=> (busy && !pulse && cnt == $past(cnt) - DLY_W'(1)));

   // R7: an expiring count fires and returns to idle
   a_r7_expire: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt == '0) |=> (pulse && !busy));
endmodule

// File: rtl/trig_cond.sv
module trig_cond
   import trig_cond_pkg::*;
#(
   parameter int N_TRIG      = 7,
   parameter int DLY_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit DELAY_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [REG_DW-1:0] reg_wdata,
   output logic [REG_DW-1:0] reg_rdata,
   input  logic [N_TRIG-1:0] trig_pin,
   output logic [N_TRIG-1:0] trig_out
);
   initial begin
      assert (N_TRIG >= 1 && N_TRIG <= REG_DW - SEL_LSB) else $error("N_TRIG out of range");
      assert (DLY_W >= 1 && DLY_W <= SEL_LSB) else $error("DLY_W out of range");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES below 2");
   end

   logic [N_TRIG-1:0] lvl_sync;
   logic [N_TRIG-1:0] in_en;
   logic [N_TRIG-1:0] out_en;
   logic [N_TRIG-1:0] dly_sel;
   logic [DLY_W-1:0]  dly_val;
   logic [N_TRIG-1:0] lvl_gated;
   logic [N_TRIG-1:0] dly_pulse;

   trig_sync #(.WIDTH(N_TRIG), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(trig_pin), .dout(lvl_sync));

   trig_regs #(.N_TRIG(N_TRIG), .DLY_W(DLY_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lvl_sync(lvl_sync),
      .in_en(in_en), .out_en(out_en), .dly_val(dly_val), .dly_sel(dly_sel));

   assign lvl_gated = lvl_sync & in_en;

   if (DELAY_EN) begin : g_delay
      for (genvar i = 0; i < N_TRIG; i++) begin : g_lane
         trig_delay_lane #(.DLY_W(DLY_W)) u_lane (
            .clk(clk), .rst_n(rst_n), .lvl(lvl_gated[i]),
            .dly(dly_val), .pulse(dly_pulse[i]));
      end
   end else begin : g_nodelay
      assign dly_pulse = '0;
   end

   assign trig_out = out_en & ((dly_sel & dly_pulse) | (~dly_sel & lvl_gated));

   // R5: a disabled output stays low on both paths
   a_r5_gate: assert property (@(posedge clk) disable iff (!rst_n)
      ((trig_out & ~out_en) == '0));
endmodule

// File: tb/trig_cond_bench.sv
module trig_cond_bench;
   localparam int N = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [N-1:0] trig_pin = '0;
   logic [N-1:0] trig_out;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   trig_cond u_trig_cond (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .trig_pin(trig_pin), .trig_out(trig_out));

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic observe(input int ln, input int n, output int first, output int cnt);
      first = 0; cnt = 0;
      for (int k = 1; k <= n; k++) begin
         @(posedge clk); #1;
         if (trig_out[ln]) begin
            if (first == 0) first = k;
            cnt++;
         end
      end
   endtask

   task automatic settle();
      @(negedge clk); trig_pin = '0;
      repeat (30) @(posedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      for (int a = 0; a <= 8'h1C; a += 4) begin
         rd(8'(a), d);
         chk("R1 reset register", d, 32'h0);
      end
      chk("R1 reset outputs", 32'(trig_out), 32'h0);
   endtask

   task automatic t_readback();
      logic [31:0] d;
      wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, d); chk("R10 in_en readback", d, 32'h7F);
      wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, d); chk("R10 out_en readback", d, 32'h7F);
      wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, d); chk("R10 delay readback", d, 32'h007F_FFFF);
      wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); chk("R10 unmapped reads zero", d, 32'h0);
      wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, d); chk("R2 status ignores write", d, 32'h0);
      wr(8'h14, 32'h0);
   endtask

   task automatic t_direct();
      logic [31:0] d;
      wr(8'h04, 32'h7F); wr(8'h10, 32'h7F); wr(8'h14, 32'h0);
      @(negedge clk); trig_pin[1] = 1'b1;
      @(posedge clk); #1; chk("R6 direct not yet", 32'(trig_out[1]), 32'h0);
      @(posedge clk); #1; chk("R6 direct after two clocks", 32'(trig_out[1]), 32'h1);
      rd(8'h08, d); chk("R2 status level", d, 32'h02);
      wr(8'h10, 32'h7D);
      #1 chk("R5 output gated off", 32'(trig_out[1]), 32'h0);
      @(negedge clk); trig_pin[1] = 1'b0;
      repeat (2) @(posedge clk); #1;
      chk("R6 direct falls", 32'(trig_out[1]), 32'h0);
      rd(8'h0C, d); chk("R5 catch unaffected by out_en", d, 32'h02);
      wr(8'h0C, 32'h0); rd(8'h0C, d); chk("R4 clear by zero", d, 32'h0);
      settle();
   endtask

   task automatic t_mask();
      logic [31:0] d;
      int first, cnt;
      wr(8'h04, 32'h77); wr(8'h10, 32'h7F); wr(8'h14, 32'h0008_0002);
      @(negedge clk); trig_pin[3] = 1'b1;
      observe(3, 12, first, cnt);
      chk("R3 masked input no output", 32'(cnt), 32'h0);
      rd(8'h0C, d); chk("R3 masked input no catch", d, 32'h0);
      rd(8'h08, d); chk("R2 status ignores enable", d, 32'h08);
      // enabling now: input already high, the rising edge is seen after enable
      wr(8'h04, 32'h7F);
      observe(3, 8, first, cnt);
      chk("R3 delay after enable, one pulse", 32'(cnt), 32'h1);
      settle();
      wr(8'h0C, 32'h0);
   endtask

   task automatic t_catch();
      logic [31:0] d;
      wr(8'h04, 32'h7F); wr(8'h14, 32'h0);
      @(negedge clk); trig_pin[0] = 1'b1; trig_pin[5] = 1'b1;
      repeat (3) @(posedge clk);
      rd(8'h0C, d); chk("R4 catch set", d, 32'h21);
      @(negedge clk); trig_pin[0] = 1'b0;
      repeat (4) @(posedge clk);
      rd(8'h0C, d); chk("R4 catch sticky after fall", d, 32'h21);
      wr(8'h0C, 32'h0);
      rd(8'h0C, d); chk("R4 set wins over clear", d, 32'h20);
      @(negedge clk); trig_pin[5] = 1'b0; trig_pin[0] = 1'b1;
      repeat (4) @(posedge clk);
      wr(8'h0C, 32'h7E);
      @(negedge clk); trig_pin[0] = 1'b0;
      repeat (4) @(posedge clk);
      wr(8'h0C, 32'h01);
      rd(8'h0C, d); chk("R4 write one keeps, zero clears", d, 32'h01);
      wr(8'h0C, 32'h0);
      settle();
   endtask

   task automatic t_delay(input int ln, input int dly);
      int first, cnt;
      wr(8'h04, 32'h7F); wr(8'h10, 32'h7F);
      wr(8'h14, (32'h1 << (16 + ln)) | 32'(dly));
      @(negedge clk); trig_pin[ln] = 1'b1;
      observe(ln, dly + 10, first, cnt);
      if (dly == 0) chk("R8 zero delay first pulse", 32'(first), 32'd3);
      else          chk("R7 delay first pulse", 32'(first), 32'(dly + 3));
      chk("R7 exactly one pulse", 32'(cnt), 32'h1);
      settle();
   endtask

   task automatic t_ignore();
      int first, cnt;
      wr(8'h04, 32'h7F); wr(8'h10, 32'h7F); wr(8'h14, 32'h0001_000A);
      @(negedge clk); trig_pin[0] = 1'b1;
      fork
         observe(0, 30, first, cnt);
         begin
            repeat (4) @(negedge clk); trig_pin[0] = 1'b0;
            repeat (3) @(negedge clk); trig_pin[0] = 1'b1;
         end
      join
      chk("R9 edge while counting ignored, timing", 32'(first), 32'd13);
      chk("R9 edge while counting ignored, count", 32'(cnt), 32'h1);
      settle();
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_readback();
      t_direct();
      t_mask();
      t_catch();
      t_delay(2, 5);
      t_delay(6, 1);
      t_delay(4, 0);
      t_delay(5, 37);
      t_ignore();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule